// File: doc/BRIEF.md
# Stream Lock Qualifier and Auto-Mute Gate

This block sits behind a serial digital-audio receiver. It takes two lock flags, one from the recovered-clock loop and one from the frame decoder, along with two payload flags: the channel-status bit that marks the stream as non-audio, and a burst-preamble detector. From these it derives a lock pin and a PCM-detect pin. It also hard-mutes the decoded multi-channel samples while the receiver is out of lock, so that downstream processing only sees valid audio.

Two configuration inputs change the defaults. `cfg_lock_only_i` makes the lock pin follow loop lock alone, ignoring the payload type. `cfg_bypass_i` turns the out-of-lock mute off. The lock qualifier is a three-state machine. `LK_SEARCH` means at least one loop is unlocked. `LK_AUDIO` means both loops are locked and the payload is PCM. `LK_DATA` means both loops are locked and the payload is not audio. The machine re-evaluates its inputs every cycle. Its transitions are acquire (`LK_SEARCH`→`LK_AUDIO`/`LK_DATA`), payload change (`LK_AUDIO`↔`LK_DATA`) and loss (`LK_AUDIO`/`LK_DATA`→`LK_SEARCH`).

The mute gate is a two-state machine, `GT_HOLD` (muted, the reset state) and `GT_PASS`. It changes state only on a sample strobe. The release transition (`GT_HOLD`→`GT_PASS`) and the engage transition (`GT_PASS`→`GT_HOLD`) are decided for the sample being taken, so a sample is always passed or zeroed as a whole. The gate mutes when bypass is off and the qualifier, as registered on the previous edge, is in `LK_SEARCH`. Payload type and any user mute control play no part in this decision.

Top module: `lkm_lock_mute`

## Requirements
- R1: After reset, `lock_o`, `pcmdet_o`, `out_vld_o` and `out_o` are 0, and `status_o` is 8'h20, which means only the mute bit is set.
- R2: With `cfg_lock_only_i`=0, `lock_o` is 1 in the cycle after an edge at which both loop-lock inputs are 1 and both `nonpcm_i` and `burst_i` are 0.
- R3: With `cfg_lock_only_i`=0, `lock_o` is 0 after an edge at which both loops are locked but `nonpcm_i` or `burst_i` is 1.
- R4: With `cfg_lock_only_i`=1, `lock_o` is 1 after any edge at which both loops are locked, whatever the payload flags. The config input acts on `lock_o` without delay.
- R5: `lock_o` is 0 after any edge at which either loop-lock input is 0, in both modes.
- R6: `pcmdet_o` is the registered value of `frm_locked_i & !nonpcm_i & !burst_i`.
- R7: Each `status_o` bit is set as follows. Bit 0 is the registered clock-loop lock. Bit 1 is the registered frame lock. Bit 2 is set when both loops are locked. Bit 3 equals `pcmdet_o`. Bit 4 equals `lock_o`. Bit 5 is set while the gate is muting. Bits 7:6 are 0.
- R8: With `cfg_bypass_i`=0, a strobed sample taken while the registered both-locked status is 0 comes out one cycle later as all zeros, with no ramp. `out_vld_o` follows `smp_vld_i` by one cycle.
- R9: A strobed sample taken while both loops are registered as locked passes unchanged, even when the payload is flagged non-audio.
- R10: With `cfg_bypass_i`=1, every strobed sample passes unchanged, even when the receiver is unlocked.
- R11: In cycles without a strobe, `out_o` and the mute status bit hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_locked_i | input | 1 | Recovered-clock loop locked |
| frm_locked_i | input | 1 | Frame decoder locked |
| nonpcm_i | input | 1 | Channel status marks payload as non-audio |
| burst_i | input | 1 | Burst preamble detected |
| cfg_lock_only_i | input | 1 | Lock pin follows loop lock only |
| cfg_bypass_i | input | 1 | Disable out-of-lock mute |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | NCH*W | Decoded samples, channel 0 in the low bits |
| lock_o | output | 1 | Qualified lock pin |
| pcmdet_o | output | 1 | PCM-detect pin |
| status_o | output | 8 | Readable status word |
| out_vld_o | output | 1 | Output sample strobe |
| out_o | output | NCH*W | Gated samples |

## Verification
The bench drives several patterns: samples streamed while unlocked, lock acquisition with PCM payload, non-audio and burst payloads under both lock-pin modes, lock loss during streaming, bypass while unlocked, and sparse strobes. The unlocked stream and the lock-loss case show the hard mute taking effect on the first sample with no ramp. The non-audio payloads tell the lock-pin qualification apart from the mute decision, which ignores payload type. Sparse strobes show that the gate state and the output only move on sample boundaries. A long run of random flags and strobes then exercises every transition of both state machines against the behavioural model.

// File: rtl/lkm_pkg.sv
package lkm_pkg;

    localparam int STW = 8;

    localparam int ST_CLK_LK  = 0;
    localparam int ST_FRM_LK  = 1;
    localparam int ST_BOTH_LK = 2;
    localparam int ST_PCM     = 3;
    localparam int ST_LOCKPIN = 4;
    localparam int ST_MUTED   = 5;

    typedef enum logic [1:0] {
        LK_SEARCH = 2'd0,
        LK_AUDIO  = 2'd1,
        LK_DATA   = 2'd2
    } lk_state_e;

    typedef enum logic {
        GT_HOLD = 1'b0,
        GT_PASS = 1'b1
    } gt_state_e;

endpackage

// File: rtl/lkm_lock_qual.sv
module lkm_lock_qual
    import lkm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clk_locked_i,
    input  logic frm_locked_i,
    input  logic nonpcm_i,
    input  logic burst_i,
    input  logic lock_only_i,
    output logic clk_lk_o,
    output logic frm_lk_o,
    output logic both_lk_o,
    output logic lock_o,
    output logic pcmdet_o
);

    lk_state_e state_q, state_d;
    logic      loops_ok;
    logic      not_audio;
    logic      clk_lk_q, frm_lk_q, pcm_q;

    assign loops_ok  = clk_locked_i & frm_locked_i;
    assign not_audio = nonpcm_i | burst_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_SEARCH: begin
                if (loops_ok)       state_d = not_audio ? LK_DATA : LK_AUDIO;
            end
            LK_AUDIO: begin
                if (!loops_ok)      state_d = LK_SEARCH;
                else if (not_audio) state_d = LK_DATA;
            end
            LK_DATA: begin
                if (!loops_ok)      state_d = LK_SEARCH;
                else if (!not_audio) state_d = LK_AUDIO;
            end
            default:                state_d = LK_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= LK_SEARCH;
            clk_lk_q <= 1'b0;
            frm_lk_q <= 1'b0;
            pcm_q    <= 1'b0;
        end else begin
            state_q  <= state_d;
            clk_lk_q <= clk_locked_i;
            frm_lk_q <= frm_locked_i;
            pcm_q    <= frm_locked_i & ~not_audio;
        end
    end

    always_comb begin
        lock_o    = 1'b0;
        both_lk_o = 1'b0;
        unique case (state_q)
            LK_SEARCH: begin
                lock_o    = 1'b0;
                both_lk_o = 1'b0;
            end
            LK_AUDIO: begin
                lock_o    = 1'b1;
                both_lk_o = 1'b1;
            end
            LK_DATA: begin
                lock_o    = lock_only_i;
                both_lk_o = 1'b1;
            end
            default: begin
                lock_o    = 1'b0;
                both_lk_o = 1'b0;
            end
        endcase
    end

    assign clk_lk_o = clk_lk_q;
    assign frm_lk_o = frm_lk_q;
    assign pcmdet_o = pcm_q;

    assert_lock_needs_loops_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |-> (clk_lk_q && frm_lk_q));

    assert_nonaudio_drops_lock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (loops_ok && not_audio && !lock_only_i) |=> (!lock_o || lock_only_i));

    assert_pcmdet_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        not_audio |=> !pcmdet_o);

    assert_lockonly_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (loops_ok && lock_only_i) |=> (lock_o || !lock_only_i));

endmodule

// File: rtl/lkm_chan_gate.sv
module lkm_chan_gate #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take_i,
    input  logic         zero_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);

    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (take_i) begin
            data_q <= zero_i ? '0 : din_i;
        end
    end

    assign dout_o = data_q;

endmodule

// File: rtl/lkm_mute_gate.sv
module lkm_mute_gate
    import lkm_pkg::*;
#(
    parameter int W   = 24,
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             both_lk_i,
    input  logic             bypass_i,
    input  logic             vld_i,
    input  logic [NCH*W-1:0] din_i,
    output logic             vld_o,
    output logic [NCH*W-1:0] dout_o,
    output logic             hold_o
);

    localparam int SW = NCH * W;

    gt_state_e state_q, state_d;
    logic      mute_req;
    logic      zero_now;
    logic      vld_q;

    assign mute_req = ~bypass_i & ~both_lk_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GT_HOLD: if (vld_i && !mute_req) state_d = GT_PASS;
            GT_PASS: if (vld_i &&  mute_req) state_d = GT_HOLD;
            default: state_d = GT_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GT_HOLD;
            vld_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            vld_q   <= vld_i;
        end
    end

    always_comb begin
        unique case (state_d)
            GT_HOLD: zero_now = 1'b1;
            GT_PASS: zero_now = 1'b0;
            default: zero_now = 1'b1;
        endcase
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lkm_chan_gate #(.W(W)) i_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .take_i (vld_i),
            .zero_i (zero_now),
            .din_i  (din_i[c*W +: W]),
            .dout_o (dout_o[c*W +: W])
        );
    end

    assign vld_o  = vld_q;
    assign hold_o = (state_q == GT_HOLD);

    assert_muted_sample_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && state_q == GT_HOLD) |-> (dout_o == '0));

    assert_gate_moves_on_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(state_q));

    assert_output_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_i |=> $stable(dout_o));

    assert_bypass_passes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && bypass_i) |=> (dout_o == $past(din_i)));

    assert_strobe_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |=> vld_o);

    initial begin
        assert_width_sane: assert (SW > 0);
    end

endmodule

// File: rtl/lkm_lock_mute.sv
module lkm_lock_mute
    import lkm_pkg::*;
#(
    parameter int W   = 24,
    parameter int NCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_locked_i,
    input  logic             frm_locked_i,
    input  logic             nonpcm_i,
    input  logic             burst_i,
    input  logic             cfg_lock_only_i,
    input  logic             cfg_bypass_i,
    input  logic             smp_vld_i,
    input  logic [NCH*W-1:0] smp_i,
    output logic             lock_o,
    output logic             pcmdet_o,
    output logic [STW-1:0]   status_o,
    output logic             out_vld_o,
    output logic [NCH*W-1:0] out_o
);

    logic clk_lk, frm_lk, both_lk, gate_hold;

    lkm_lock_qual i_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_locked_i (clk_locked_i),
        .frm_locked_i (frm_locked_i),
        .nonpcm_i     (nonpcm_i),
        .burst_i      (burst_i),
        .lock_only_i  (cfg_lock_only_i),
        .clk_lk_o     (clk_lk),
        .frm_lk_o     (frm_lk),
        .both_lk_o    (both_lk),
        .lock_o       (lock_o),
        .pcmdet_o     (pcmdet_o)
    );

    lkm_mute_gate #(.W(W), .NCH(NCH)) i_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .both_lk_i (both_lk),
        .bypass_i  (cfg_bypass_i),
        .vld_i     (smp_vld_i),
        .din_i     (smp_i),
        .vld_o     (out_vld_o),
        .dout_o    (out_o),
        .hold_o    (gate_hold)
    );

    always_comb begin
        status_o             = '0;
        status_o[ST_CLK_LK]  = clk_lk;
        status_o[ST_FRM_LK]  = frm_lk;
        status_o[ST_BOTH_LK] = both_lk;
        status_o[ST_PCM]     = pcmdet_o;
        status_o[ST_LOCKPIN] = lock_o;
        status_o[ST_MUTED]   = gate_hold;
    end

    assert_mute_only_unlocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && both_lk) |=> !gate_hold);

endmodule

// File: tb/test_lkm_lock_mute.sv
`timescale 1ns/1ps
module test_lkm_lock_mute;

    localparam int W   = 24;
    localparam int NCH = 2;
    localparam int SW  = NCH * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ck = 0, fr = 0, np = 0, bu = 0, lo = 0, by = 0, vl = 0;
    logic [SW-1:0] smp = '0;

    logic          lock_o, pcmdet_o, out_vld_o;
    logic [7:0]    status_o;
    logic [SW-1:0] out_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    int            m_st = 0;      // 0 search, 1 audio, 2 data
    bit            m_clk = 0, m_frm = 0, m_pcm = 0, m_hold = 1, m_ovld = 0;
    logic [SW-1:0] m_out = '0;

    always #4 clk = ~clk;

    lkm_lock_mute #(.W(W), .NCH(NCH)) i_lkm_lock_mute (
        .clk(clk), .rst_n(rst_n),
        .clk_locked_i(ck), .frm_locked_i(fr), .nonpcm_i(np), .burst_i(bu),
        .cfg_lock_only_i(lo), .cfg_bypass_i(by),
        .smp_vld_i(vl), .smp_i(smp),
        .lock_o(lock_o), .pcmdet_o(pcmdet_o), .status_o(status_o),
        .out_vld_o(out_vld_o), .out_o(out_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [SW-1:0] act, input logic [SW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit dec;
        if (!rst_n) begin
            m_st = 0; m_clk = 0; m_frm = 0; m_pcm = 0; m_hold = 1; m_ovld = 0; m_out = '0;
        end else begin
            dec = !by && (m_st == 0);
            if (vl) begin
                m_hold = dec;
                m_out  = dec ? '0 : smp;
            end
            m_ovld = vl;
            m_clk  = ck;
            m_frm  = fr;
            m_pcm  = fr && !np && !bu;
            if (!(ck && fr)) m_st = 0;
            else if (np || bu) m_st = 2;
            else m_st = 1;
        end
    endtask

    task automatic compare();
        bit lk;
        string ltag, dtag;
        lk = lo ? (m_st != 0) : (m_st == 1);
        if (m_st == 0) ltag = "R5";
        else if (lo) ltag = "R4";
        else if (m_st == 1) ltag = "R2";
        else ltag = "R3";
        chk(ltag, "lock_o", SW'(lock_o), SW'(lk));
        chk("R6", "pcmdet_o", SW'(pcmdet_o), SW'(m_pcm));
        chk("R7", "status_o", SW'(status_o),
            SW'({2'b00, m_hold, lk, m_pcm, (m_st != 0), m_frm, m_clk}));
        chk("R8", "out_vld_o", SW'(out_vld_o), SW'(m_ovld));
        if (!m_ovld) dtag = "R11";
        else if (by) dtag = "R10";
        else if (m_hold) dtag = "R8";
        else dtag = "R9";
        chk(dtag, "out_o", out_o, m_out);
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic drive(input bit c, input bit f, input bit n, input bit b,
                         input bit l, input bit y, input bit v);
        ck = c; fr = f; np = n; bu = b; lo = l; by = y; vl = v;
        smp = SW'({$urandom(), $urandom()});
        cyc();
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk("R1", "lock_o", SW'(lock_o), '0);
        chk("R1", "pcmdet_o", SW'(pcmdet_o), '0);
        chk("R1", "status_o", SW'(status_o), SW'(8'h20));
        chk("R1", "out_vld_o", SW'(out_vld_o), '0);
        chk("R1", "out_o", out_o, '0);

        // R8: samples while unlocked are zeroed
        for (int i = 0; i < 6; i++) drive(0, 0, 0, 0, 0, 0, 1);
        // only one loop locked: still muted, lock low (R5)
        for (int i = 0; i < 4; i++) drive(1, 0, 0, 0, 0, 0, 1);
        for (int i = 0; i < 4; i++) drive(0, 1, 0, 0, 0, 0, 1);
        // R2 / R9: acquire with PCM payload
        for (int i = 0; i < 8; i++) drive(1, 1, 0, 0, 0, 0, 1);
        // R3: non-audio and burst drop lock, samples still pass (R9)
        for (int i = 0; i < 4; i++) drive(1, 1, 1, 0, 0, 0, 1);
        for (int i = 0; i < 4; i++) drive(1, 1, 0, 1, 0, 0, 1);
        // R4: lock-only mode
        for (int i = 0; i < 4; i++) drive(1, 1, 1, 1, 1, 0, 1);
        drive(1, 1, 1, 0, 0, 0, 0);
        drive(1, 1, 1, 0, 1, 0, 0);
        // R5 / R8: loss of lock mid-stream
        for (int i = 0; i < 4; i++) drive(0, 1, 0, 0, 1, 0, 1);
        // R10: bypass while unlocked
        for (int i = 0; i < 6; i++) drive(0, 0, 0, 0, 0, 1, 1);
        // R11: sparse strobes across a lock change
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 1);
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0, 0);
        drive(1, 1, 0, 0, 0, 0, 1);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            drive(($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 4) == 0,
                  ($urandom % 6) == 0, ($urandom % 3) == 0, ($urandom % 5) == 0,
                  ($urandom % 3) != 0);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule